// File: doc/BRIEF.md
# Push-Button Stepped Volume Controller

This block turns three push buttons into one attenuation code that sets the level of two audio channels together. A free-running slow tick sets the stepping pace. The tick reaches the level counter only while exactly one of the raise or lower buttons is held. Holding a button therefore moves the level one step per tick until the button is released or the level reaches a limit. A third button drops the level to its minimum. The level register drives two identical groups of active-high switch enables, one group per channel. Within a group, each enable bypasses one series resistor segment of that channel's ladder.

Every button passes through a two-flop synchroniser and a debounce filter. The filtered buttons select one of four named states in a small state machine:
- ST_IDLE: no step is taken.
- ST_RAISE: the level steps up on each tick.
- ST_LOWER: the level steps down on each tick.
- ST_CLEAR: the level is forced to zero.

The state is recomputed on every clock from the filtered buttons, with this priority:
- clear held: any state goes to ST_CLEAR.
- otherwise, raise alone: any state goes to ST_RAISE.
- otherwise, lower alone: any state goes to ST_LOWER.
- otherwise (neither button, or both): any state goes to ST_IDLE.

Top module: `stepvol_ctrl`

## Requirements
- R1: While rst_n is low, and on the first clock after it rises, both enable groups read 0000.
- R2: Each button is synchronised by two flops. A change on a button is accepted only after the synchronised value has differed from the accepted value for DEB_CYCLES consecutive clocks, so shorter pulses have no effect on the level.
- R3: The step tick is free running with a period of TICK_DIV clocks. While a step button is held, successive level changes are exactly TICK_DIV clocks apart.
- R4: While the raise button alone is accepted as held, each tick adds one to the level.
- R5: While the lower button alone is accepted as held, each tick subtracts one from the level.
- R6: The level saturates. A raise at 15 (all enables high, maximum volume) leaves it at 15, and a lower at 0 (all enables low, minimum volume) leaves it at 0.
- R7: When raise and lower are both accepted as held, the level does not change.
- R8: The clear button has priority over raise and lower. While it is accepted as held, the level is 0 from the clock after the state machine enters ST_CLEAR.
- R9: Bit i of ch_a_en_o and bit i of ch_b_en_o both equal bit i of the level (bit 0 is the least significant bit, which bypasses the smallest segment), so the two groups are always identical.
- R10: The level follows the cycle-exact chain: synchroniser, debounce, state register, then level register clocked on the tick.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_up_i | input | 1 | Raise button, asynchronous, high while pressed |
| btn_dn_i | input | 1 | Lower button, asynchronous, high while pressed |
| btn_clr_i | input | 1 | Clear-to-minimum button, asynchronous, high while pressed |
| ch_a_en_o | output | LEVEL_W | Segment-bypass enables for channel A, active high |
| ch_b_en_o | output | LEVEL_W | Segment-bypass enables for channel B, active high |

## Verification
The assertions check the following on every cycle:
- the two enable groups always match;
- the level never moves by more than one step except to zero;
- the level never wraps at either limit;
- a nonzero change only follows a tick;
- ticks are exactly TICK_DIV clocks apart;
- the clock after ST_CLEAR always shows zero.

Some behaviour can only be shown by the bench's scenarios:
- debounce rejection of short pulses;
- the exact pacing of steps while a button is held;
- the no-step rule for simultaneous presses;
- clear priority over a held raise;
- the cycle-exact latency through the whole chain.

The bench checks these against its own model, under directed presses and random button sequences.

// File: rtl/stepvol_pkg.sv
package stepvol_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RAISE = 2'd1,
        ST_LOWER = 2'd2,
        ST_CLEAR = 2'd3
    } step_state_e;

    localparam int unsigned BTN_UP  = 0;
    localparam int unsigned BTN_DN  = 1;
    localparam int unsigned BTN_CLR = 2;
    localparam int unsigned BTN_NUM = 3;
endpackage

// File: rtl/stepvol_btn_filter.sv
module stepvol_btn_filter #(
    parameter int unsigned DEB_CYCLES = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic clean_o
);
    localparam int unsigned CW = $clog2(DEB_CYCLES + 1);

    logic          sync_q1;
    logic          sync_q2;
    logic [CW-1:0] run_q;

    // two-flop synchroniser for an asynchronous button
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q1 <= 1'b0;
            sync_q2 <= 1'b0;
        end else begin
            sync_q1 <= raw_i;
            sync_q2 <= sync_q1;
        end
    end

    // accept a new value only after it persists for DEB_CYCLES clocks
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run_q   <= '0;
            clean_o <= 1'b0;
        end else if (sync_q2 == clean_o) begin
            run_q <= '0;
        end else if (run_q == CW'(DEB_CYCLES - 1)) begin
            clean_o <= sync_q2;
            run_q   <= '0;
        end else begin
            run_q <= run_q + 1'b1;
        end
    end
endmodule

// File: rtl/stepvol_tick_gen.sv
module stepvol_tick_gen #(
    parameter int unsigned TICK_DIV = 16
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int unsigned CW = (TICK_DIV > 2) ? $clog2(TICK_DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(TICK_DIV - 1);

    logic [CW-1:0] div_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)             div_q <= '0;
        else if (div_q == LAST) div_q <= '0;
        else                    div_q <= div_q + 1'b1;
    end

    assign tick_o = (div_q == LAST);
endmodule

// File: rtl/stepvol_level_fsm.sv
module stepvol_level_fsm
    import stepvol_pkg::*;
#(
    parameter int unsigned LEVEL_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               up_i,
    input  logic               dn_i,
    input  logic               clr_i,
    input  logic               tick_i,
    output step_state_e        state_o,
    output logic [LEVEL_W-1:0] level_o
);
    localparam logic [LEVEL_W-1:0] LVL_MAX = '1;
    localparam logic [LEVEL_W-1:0] LVL_MIN = '0;

    step_state_e state_q;
    step_state_e state_d;

    // next state: clear wins, then a single held direction
    always_comb begin
        if (clr_i)              state_d = ST_CLEAR;
        else if (up_i && !dn_i) state_d = ST_RAISE;
        else if (dn_i && !up_i) state_d = ST_LOWER;
        else                    state_d = ST_IDLE;
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // output register: saturating level
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            level_o <= LVL_MIN;
        end else begin
            unique case (state_q)
                ST_IDLE:  level_o <= level_o;
                ST_RAISE: if (tick_i && level_o != LVL_MAX) level_o <= level_o + 1'b1;
                ST_LOWER: if (tick_i && level_o != LVL_MIN) level_o <= level_o - 1'b1;
                ST_CLEAR: level_o <= LVL_MIN;
                default:  level_o <= level_o;
            endcase
        end
    end

    assign state_o = state_q;
endmodule

// File: rtl/stepvol_ctrl.sv
module stepvol_ctrl
    import stepvol_pkg::*;
#(
    parameter int unsigned LEVEL_W    = 4,
    parameter int unsigned TICK_DIV   = 16,
    parameter int unsigned DEB_CYCLES = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               btn_up_i,
    input  logic               btn_dn_i,
    input  logic               btn_clr_i,
    output logic [LEVEL_W-1:0] ch_a_en_o,
    output logic [LEVEL_W-1:0] ch_b_en_o
);
    logic [BTN_NUM-1:0] btn_raw;
    logic [BTN_NUM-1:0] btn_clean;
    logic               step_tick;
    step_state_e        fsm_state;
    logic [LEVEL_W-1:0] level;

    assign btn_raw[BTN_UP]  = btn_up_i;
    assign btn_raw[BTN_DN]  = btn_dn_i;
    assign btn_raw[BTN_CLR] = btn_clr_i;

    for (genvar b = 0; b < BTN_NUM; b++) begin : g_btn
        stepvol_btn_filter #(.DEB_CYCLES(DEB_CYCLES)) u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .raw_i   (btn_raw[b]),
            .clean_o (btn_clean[b])
        );
    end

    stepvol_tick_gen #(.TICK_DIV(TICK_DIV)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (step_tick)
    );

    stepvol_level_fsm #(.LEVEL_W(LEVEL_W)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .up_i    (btn_clean[BTN_UP]),
        .dn_i    (btn_clean[BTN_DN]),
        .clr_i   (btn_clean[BTN_CLR]),
        .tick_i  (step_tick),
        .state_o (fsm_state),
        .level_o (level)
    );

    assign ch_a_en_o = level;
    assign ch_b_en_o = level;
endmodule

// File: rtl/stepvol_check.sv
module stepvol_check
    import stepvol_pkg::*;
#(
    parameter int unsigned LEVEL_W  = 4,
    parameter int unsigned TICK_DIV = 16
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tick,
    input step_state_e        state,
    input logic [LEVEL_W-1:0] code_a,
    input logic [LEVEL_W-1:0] code_b
);
    localparam logic [LEVEL_W-1:0] LVL_MAX = '1;

    int unsigned gap_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    gap_q <= 0;
        else if (tick) gap_q <= 0;
        else           gap_q <= gap_q + 1;
    end

    p_same_code_r9: assert property (@(posedge clk) disable iff (!rst_n)
        code_a == code_b);

    p_single_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a != $past(code_a)) |->
        (code_a == $past(code_a) + 1'b1 || code_a == $past(code_a) - 1'b1 || code_a == '0));

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_a) == LVL_MAX) |-> (code_a == LVL_MAX || code_a == LVL_MAX - 1'b1 || code_a == '0));

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(code_a) == '0) |-> (code_a <= LEVEL_W'(1)));

    p_step_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (code_a != $past(code_a) && code_a != '0) |-> $past(tick));

    p_tick_period_r3: assert property (@(posedge clk) disable iff (!rst_n)
        tick |-> (gap_q == TICK_DIV - 1));

    p_clear_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CLEAR) |=> (code_a == '0));
endmodule

bind stepvol_ctrl stepvol_check #(.LEVEL_W(LEVEL_W), .TICK_DIV(TICK_DIV)) u_check (
    .clk    (clk),
    .rst_n  (rst_n),
    .tick   (step_tick),
    .state  (fsm_state),
    .code_a (ch_a_en_o),
    .code_b (ch_b_en_o)
);

// File: tb/stepvol_ctrl_bench.sv
module stepvol_ctrl_bench;
    localparam int LW   = 4;
    localparam int TDIV = 20;
    localparam int DEB  = 5;
    localparam int MAXL = (1 << LW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic up = 1'b0, dn = 1'b0, clr = 1'b0;
    logic [LW-1:0] ch_a, ch_b;

    int n_tests = 0;
    int n_fail  = 0;
    bit done = 1'b0;
    string cur_tag = "R1";

    always #5 clk = ~clk;

    stepvol_ctrl #(.LEVEL_W(LW), .TICK_DIV(TDIV), .DEB_CYCLES(DEB)) u_stepvol_ctrl (
        .clk(clk), .rst_n(rst_n), .btn_up_i(up), .btn_dn_i(dn), .btn_clr_i(clr),
        .ch_a_en_o(ch_a), .ch_b_en_o(ch_b)
    );

    // reference model built from the requirements
    bit [2:0] m_s1, m_s2, m_cl;
    int       m_run [3];
    int       m_div;
    int       m_st;      // 0 idle, 1 raise, 2 lower, 3 clear
    int       m_lvl;

    function automatic int next_mode(bit u, bit d, bit c);
        if (c)       return 3;
        if (u && !d) return 1;
        if (d && !u) return 2;
        return 0;
    endfunction

    function automatic int next_level(int st, int lvl, bit tk);
        if (st == 3)                      return 0;
        if (st == 1 && tk && lvl < MAXL)  return lvl + 1;
        if (st == 2 && tk && lvl > 0)     return lvl - 1;
        return lvl;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_cl <= '0;
            for (int b = 0; b < 3; b++) m_run[b] <= 0;
            m_div <= 0; m_st <= 0; m_lvl <= 0;
        end else begin
            m_s1 <= {clr, dn, up};
            m_s2 <= m_s1;
            for (int b = 0; b < 3; b++) begin
                if (m_s2[b] == m_cl[b]) m_run[b] <= 0;
                else if (m_run[b] == DEB - 1) begin m_cl[b] <= m_s2[b]; m_run[b] <= 0; end
                else m_run[b] <= m_run[b] + 1;
            end
            m_div <= (m_div == TDIV - 1) ? 0 : m_div + 1;
            m_st  <= next_mode(m_cl[0], m_cl[1], m_cl[2]);
            m_lvl <= next_level(m_st, m_lvl, m_div == TDIV - 1);
        end
    end

    task automatic check(string tag, int act, int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
        end
    endtask

    // continuous cycle-exact comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            check(cur_tag, int'(ch_a), m_lvl);
            check("R9", int'(ch_b), int'(ch_a));
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        cycles(3 * DEB + 10);
    endtask

    // negedges until the level changes, capped
    task automatic wait_change(output int n);
        logic [LW-1:0] prev;
        prev = ch_a;
        n = 0;
        while (ch_a == prev && n < 10 * TDIV) begin
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        int gap;
        int base;
        void'($urandom(32'd20240611));
        cycles(4);
        check("R1", int'(ch_a), 0);
        check("R1", int'(ch_b), 0);
        rst_n = 1'b1;
        cycles(1);
        check("R1", int'(ch_a), 0);

        // R2: pulses shorter than the debounce window are rejected
        cur_tag = "R2";
        for (int i = 0; i < 12; i++) begin
            up = 1'b1; cycles(DEB - 1); up = 1'b0; cycles(DEB + 3);
        end
        settle();
        check("R2", int'(ch_a), 0);

        // R3/R4: steps of one, TICK_DIV apart
        cur_tag = "R4";
        up = 1'b1;
        wait_change(gap);
        base = int'(ch_a);
        check("R4", base, 1);
        wait_change(gap);
        check("R3", gap, TDIV);
        check("R4", int'(ch_a), base + 1);
        wait_change(gap);
        check("R3", gap, TDIV);

        // R6: saturation at the top
        cur_tag = "R6";
        cycles(20 * TDIV);
        up = 1'b0; settle();
        check("R6", int'(ch_a), MAXL);

        // R7: both held, no step
        cur_tag = "R7";
        up = 1'b1; dn = 1'b1;
        cycles(6 * TDIV);
        up = 1'b0; dn = 1'b0; settle();
        check("R7", int'(ch_a), MAXL);

        // R5: lower steps down by one
        cur_tag = "R5";
        dn = 1'b1;
        wait_change(gap);
        check("R5", int'(ch_a), MAXL - 1);
        wait_change(gap);
        check("R3", gap, TDIV);
        check("R5", int'(ch_a), MAXL - 2);

        // R6: saturation at the bottom
        cur_tag = "R6";
        cycles(20 * TDIV);
        dn = 1'b0; settle();
        check("R6", int'(ch_a), 0);

        // R8: clear wins over a held raise
        cur_tag = "R8";
        up = 1'b1;
        cycles(6 * TDIV);
        clr = 1'b1;
        cycles(4 * TDIV);
        check("R8", int'(ch_a), 0);
        clr = 1'b0; up = 1'b0; settle();
        check("R8", int'(ch_a), 0);

        // R10: random button sequences against the model
        cur_tag = "R10";
        for (int i = 0; i < 400; i++) begin
            int sel;
            sel = int'($urandom_range(0, 9));
            up  = (sel < 4) || (sel == 8);
            dn  = (sel >= 4 && sel < 7) || (sel == 8);
            clr = (sel == 9) && ($urandom_range(0, 3) == 0);
            cycles(int'($urandom_range(1, 3 * TDIV)));
        end
        up = 1'b0; dn = 1'b0; clr = 1'b0;
        settle();

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_tests++;
            n_fail++;
            $display("FAIL R10: watchdog actual hung expected finish");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule